// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Arbiter

This block decides which of N devices owns a shared bus. The request vector is reduced to one shared request line. When the bus is free and that line is high, the controller fires a grant into the top of a chain of pass-through stages. Device 0 sits at the top of the chain and has the highest priority. Each stage keeps the grant if its device is requesting and is allowed to take it. Otherwise the stage hands the grant on to the next stage down. The grant is captured on a clock edge.

The winning device keeps the bus until it either drops its request or pulses its release input. The cycle after that is an arbitration cycle, and a new grant can be issued at the end of it. A fairness input can be set so that the device that just gave up the bus is skipped for the round that immediately follows its tenure. The chain then passes the grant to the next eligible requester. When no other device takes the grant in that round, the skipped device wins the round after.

Top module: `dc_arbiter`

## Requirements
- R1: While rst_ni is low, and directly after reset, grant_o is all zero and busy_o is low.
- R2: When no bit of req_i is set, no grant is issued and busy_o stays low.
- R3: If the bus is free and at least one device requests at a rising edge, grant_o shows the winner right after that edge.
- R4: Bit k of req_i, rel_i and grant_o belongs to device k. The winner is the lowest-index requester that is eligible, and no eligible requester at a lower index is passed over.
- R5: grant_o never has more than one bit set.
- R6: While the owner keeps its request high and its release low, grant_o does not change. Requests and release pulses from other devices have no effect on it.
- R7: When the owner's req_i bit is low or its rel_i bit is high at an edge, grant_o becomes zero after that edge. A new grant can appear one edge later at the earliest.
- R8: busy_o is high exactly when a grant is held.
- R9: With fair_i high, the device that owned the previous tenure is skipped in the arbitration round that directly follows it. The grant goes to the lowest-index other requester.
- R10: With fair_i high, if the previous owner was the only requester when it was skipped, that round issues no grant, and the next edge grants it.
- R11: With fair_i low, the previous owner can win the round right after its own release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fair_i | input | 1 | Enables skipping the previous owner for one round |
| req_i | input | N | Per-device bus request |
| rel_i | input | N | Per-device release pulse; has an effect only for the owner |
| grant_o | output | N | Per-device grant, at most one bit set |
| busy_o | output | 1 | Bus is owned |

## Verification
The hardest situation to reach is the arbitration round that follows a tenure while fairness is on. Reaching it needs a known previous owner, a release, and a fresh request pattern that arrives exactly in the arbitration cycle. The bench first gives ownership to each device in turn. It then releases through rel_i while it applies every 4-bit request pattern, both with fairness on and with fairness off. That sweep covers the skip onto lower-priority devices, the empty round when only the skipped device is requesting, and the immediate re-grant when fairness is off.

// File: rtl/dc_arb_pkg.sv
package dc_arb_pkg;
  typedef enum logic {
    BUS_FREE = 1'b0,
    BUS_HELD = 1'b1
  } bus_state_e;
endpackage

// File: rtl/dc_chain_stage.sv
module dc_chain_stage (
  input  logic grant_in_i,
  input  logic req_i,
  input  logic block_i,
  output logic take_o,
  output logic grant_out_o
);
  assign take_o      = grant_in_i & req_i & ~block_i;
  assign grant_out_o = grant_in_i & ~take_o;
endmodule

// File: rtl/dc_chain.sv
module dc_chain #(
  parameter int unsigned N = 4
) (
  input  logic         fire_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] block_i,
  output logic [N-1:0] take_o
);
  logic [N:0] ripple;
  assign ripple[0] = fire_i;

  for (genvar k = 0; k < N; k++) begin : g_stage
    dc_chain_stage u_stage (
      .grant_in_i (ripple[k]),
      .req_i      (req_i[k]),
      .block_i    (block_i[k]),
      .take_o     (take_o[k]),
      .grant_out_o(ripple[k+1])
    );
  end
endmodule

// File: rtl/dc_owner_ctrl.sv
module dc_owner_ctrl
  import dc_arb_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] rel_i,
  input  logic [N-1:0] take_i,
  output logic         free_o,
  output logic [N-1:0] grant_o,
  output logic [N-1:0] last_o,
  output logic         busy_o
);
  bus_state_e   state_q;
  logic [N-1:0] grant_q, last_q;
  logic         release_w;

  assign release_w = |(grant_q & (~req_i | rel_i));
  assign free_o    = (state_q == BUS_FREE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUS_FREE;
      grant_q <= '0;
      last_q  <= '0;
    end else if (state_q == BUS_FREE) begin
      last_q <= '0;  // one round of exclusion only
      if (|take_i) begin
        grant_q <= take_i;
        state_q <= BUS_HELD;
      end
    end else if (release_w) begin
      last_q  <= grant_q;
      grant_q <= '0;
      state_q <= BUS_FREE;
    end
  end

  assign grant_o = grant_q;
  assign last_o  = last_q;
  assign busy_o  = (state_q == BUS_HELD);

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_q)); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUS_HELD && !release_w) |=> $stable(grant_q)); // R6
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_w |=> (grant_q == '0)); // R7
  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && grant_q == '0) |=> (grant_q == '0)); // R2
  AST_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (grant_q != '0)); // R8
endmodule

// File: rtl/dc_arbiter.sv
module dc_arbiter #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fair_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] rel_i,
  output logic [N-1:0] grant_o,
  output logic         busy_o
);
  localparam logic [N-1:0] ONE = N'(1);

  logic         req_any, free, fire;
  logic [N-1:0] take, last, block;

  assign req_any = |req_i;  // shared request line
  assign fire    = free & req_any;
  assign block   = fair_i ? last : '0;

  dc_chain #(.N(N)) u_chain (
    .fire_i (fire),
    .req_i  (req_i),
    .block_i(block),
    .take_o (take)
  );

  dc_owner_ctrl #(.N(N)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .rel_i  (rel_i),
    .take_i (take),
    .free_o (free),
    .grant_o(grant_o),
    .last_o (last),
    .busy_o (busy_o)
  );

  AST_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (((grant_o - ONE) & $past(req_i & ~block)) == '0)); // R4
  AST_FAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && $past(fair_i)) |-> ((grant_o & $past(last)) == '0)); // R9
  AST_GRANT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ((grant_o & ~$past(req_i)) == '0)); // R3
endmodule

// File: tb/tb_dc_arbiter.sv
`timescale 1ns/1ps
module tb_dc_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         fair_i = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] rel_i = '0;
  logic [N-1:0] grant_o;
  logic         busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dc_arbiter #(.N(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .fair_i(fair_i),
    .req_i(req_i), .rel_i(rel_i), .grant_o(grant_o), .busy_o(busy_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] lowest(input logic [N-1:0] m);
    return m & (~m + N'(1));
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 grant in reset", grant_o, '0);
    chk("R1 busy in reset", {3'b0, busy_o}, '0);
    rst_ni = 1'b1;
    tick();
    chk("R1 grant after reset", grant_o, '0);

    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2 grant idle", grant_o, '0);
      chk("R2 busy idle", {3'b0, busy_o}, '0);
    end

    req_i = 4'b0100;
    tick();
    chk("R3 grant after edge", grant_o, 4'b0100);
    chk("R8 busy held", {3'b0, busy_o}, 4'b0001);
    req_i = 4'b0111;
    rel_i = 4'b0011;
    tick();
    chk("R6 hold vs others", grant_o, 4'b0100);
    tick();
    chk("R6 hold second cycle", grant_o, 4'b0100);
    rel_i = '0;
    req_i = 4'b0011;
    tick();
    chk("R7 drop on req low", grant_o, '0);
    chk("R8 busy free", {3'b0, busy_o}, '0);
    tick();
    chk("R4 top of chain wins", grant_o, 4'b0001);
    req_i = '0;
    tick();
    tick();

    for (int f = 0; f < 2; f++) begin
      for (int p = 0; p <= N; p++) begin
        for (int pat = 0; pat < 16; pat++) begin
          logic [N-1:0] blk, exp;
          fair_i = f[0];
          req_i = '0;
          rel_i = '0;
          tick(); tick();
          blk = (f == 1 && p < N) ? (N'(1) << p) : '0;
          if (p < N) begin
            req_i = N'(1) << p;
            tick();
            chk("R3 owner set", grant_o, N'(1) << p);
            req_i = pat[N-1:0];
            rel_i = N'(1) << p;
            tick();
            chk("R7 drop on release", grant_o, '0);
            rel_i = '0;
          end else begin
            req_i = pat[N-1:0];
          end
          tick();
          exp = lowest(pat[N-1:0] & ~blk);
          if (f == 1) chk("R9 fair round", grant_o, exp);
          else if (p < N) chk("R11 unfair round", grant_o, exp);
          else chk("R4 priority", grant_o, exp);
          if (exp == '0 && pat != 0) begin
            tick();
            chk("R10 skipped later wins", grant_o, lowest(pat[N-1:0]));
          end
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule